// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the host-facing register front end of an eight-input programmable interrupt controller. A byte-wide bus with a single address bit reaches two ports. After reset the block walks a short initialization sequence of command words, the length of which depends on two bits of the first word. It then decodes the operational commands that arrive on the same two ports.

The sequencer holds four things. The first is the interrupt mask. The second is the words captured during initialization. The third is the last priority/end-of-interrupt command. The fourth is a read-select field that decides what a port 0 read returns.

Toward the request/service core it exports the vector base, the mask and a one-cycle decoded end-of-interrupt strobe. The core supplies its pending-request and in-service bit vectors, which are read back through port 0. Request latching and priority resolution live in that core, not here.

Top module: `pic_cmd_seq`

## Requirements
- R1: A synchronous active-high reset sets `seq_phase` to 0 (waiting for word 1). It clears `irq_mask`, `cmd_word`, `vec_base`, `cascade_map`, `mode_word` and `last_prio_cmd`, and sets the read-select field to binary 10. After reset a port 0 read therefore returns `req_bits`.
- R2: In phase 0, any port 0 write stores its byte in `cmd_word` and moves `seq_phase` to 1 (waiting for word 2).
- R3: In phase 1, a port 1 write loads `vec_base` from data bits 7:3. The next phase is then chosen from `cmd_word`. If bit 1 (single) is 0, it goes to 2 (waiting for word 3). Otherwise, if bit 0 (fourth word needed) is 1, it goes to 3 (waiting for word 4). Otherwise it goes to 4 (ready).
- R4: In phase 2, a port 1 write loads `cascade_map` and moves to 3 if `cmd_word` bit 0 is 1, else to 4. In phase 3, a port 1 write loads `mode_word` and always moves to 4. `init_done` is 1 exactly in phase 4.
- R5: In phase 4, a port 1 write loads `irq_mask` with the data byte.
- R6: In phase 4, a port 0 write with bits 4:3 = 00 is stored in `last_prio_cmd`. On the following cycle, for that cycle only, `eoi_valid` is 1 when data bit 5 is 1 and bit 7 is 0. In that cycle `eoi_specific` equals data bit 6 and `eoi_level` equals data bits 2:0. Other values in this command produce no strobe and leave the mask unchanged.
- R7: In phase 4, a port 0 write with bits 4:3 = 01 stores data bits 1:0 as the read-select field.
- R8: A port 0 read returns `req_bits` when the read-select field is 10, `svc_bits` when it is 11, and zero otherwise. `rdata` is zero whenever `rd_en` is 0.
- R9: A port 1 read returns `irq_mask`.
- R10: In any phase, a port 0 write with bit 4 set restarts initialization. The byte goes into `cmd_word`, `irq_mask` clears and `seq_phase` becomes 1.
- R11: A write that does not fit the current phase changes nothing. This covers a port 1 write in phase 0 and a port 0 write with bit 4 clear in phases 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe, combinational read data |
| addr | input | 1 | Port select, 0 or 1 |
| wdata | input | 8 | Write data |
| req_bits | input | 8 | Pending-request vector from the core |
| svc_bits | input | 8 | In-service vector from the core |
| rdata | output | 8 | Read data |
| seq_phase | output | 3 | Sequencer phase, 0..4 as in R1-R4 |
| init_done | output | 1 | High in the ready phase |
| cmd_word | output | 8 | Captured first initialization word |
| vec_base | output | 5 | Vector base from word 2 bits 7:3 |
| cascade_map | output | 8 | Captured third word |
| mode_word | output | 8 | Captured fourth word |
| irq_mask | output | 8 | Interrupt mask |
| last_prio_cmd | output | 8 | Last stored priority/EOI command |
| eoi_valid | output | 1 | One-cycle end-of-interrupt strobe |
| eoi_specific | output | 1 | Strobe names a level (1) or the highest in service (0) |
| eoi_level | output | 3 | Level for a specific end-of-interrupt |

## Verification
The bench builds the block with its default values: an 8-bit bus and a read-select reset of binary 10. This keeps the whole command space at 256 codes, so every port 0 command byte is applied in the ready phase. Each byte is classified arithmetically as restart, priority/end-of-interrupt or read-select, and checked against the strobe, mask and read-back. All 256 mask values are written and read back. All four combinations of the single and fourth-word bits are walked through the initialization path, together with an ignored write in each waiting phase and a restart from the middle of the sequence.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int LVL_W  = 3;
    localparam int VEC_W  = BYTE_W - LVL_W;

    typedef enum logic [2:0] {
        PH_WAIT_W1 = 3'd0,
        PH_WAIT_W2 = 3'd1,
        PH_WAIT_W3 = 3'd2,
        PH_WAIT_W4 = 3'd3,
        PH_READY   = 3'd4
    } phase_e;

    // first initialization word, field positions fixed by the sequence rules
    typedef struct packed {
        logic [2:0] rsvd;
        logic       start_bit;
        logic       level_trig;
        logic       interval4;
        logic       single;
        logic       need_w4;
    } word1_t;

    // priority / end-of-interrupt command
    typedef struct packed {
        logic             rotate;
        logic             specific;
        logic             eoi;
        logic [1:0]       kind;
        logic [LVL_W-1:0] level;
    } prio_cmd_t;

    typedef struct packed {
        logic             valid;
        logic             specific;
        logic [LVL_W-1:0] level;
    } eoi_t;

    localparam logic [1:0] KIND_PRIO = 2'b00;
    localparam logic [1:0] KIND_SEL  = 2'b01;
    localparam logic [1:0] RSEL_REQ  = 2'b10;
    localparam logic [1:0] RSEL_SVC  = 2'b11;

    function automatic logic is_restart(input logic wr, input logic port,
                                        input logic [BYTE_W-1:0] d);
        return wr && !port && d[4];
    endfunction

    function automatic phase_e phase_after_w2(input word1_t w);
        if (!w.single)    return PH_WAIT_W3;
        else if (w.need_w4) return PH_WAIT_W4;
        else              return PH_READY;
    endfunction

    function automatic phase_e phase_after_w3(input word1_t w);
        return w.need_w4 ? PH_WAIT_W4 : PH_READY;
    endfunction

    function automatic eoi_t decode_eoi(input prio_cmd_t c);
        eoi_t e;
        e.valid    = c.eoi && !c.rotate;
        e.specific = c.specific;
        e.level    = c.level;
        return e;
    endfunction

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    output phase_e            phase,
    output word1_t            w1,
    output logic [VEC_W-1:0]  vec_base,
    output logic [BYTE_W-1:0] w3,
    output logic [BYTE_W-1:0] w4,
    output logic              restart
);

    logic take_w1;

    assign restart = is_restart(wr_en, addr, wdata);
    assign take_w1 = restart || (wr_en && !addr && phase == PH_WAIT_W1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_WAIT_W1;
            w1       <= '0;
            vec_base <= '0;
            w3       <= '0;
            w4       <= '0;
        end else if (take_w1) begin
            w1    <= word1_t'(wdata);
            phase <= PH_WAIT_W2;
        end else if (wr_en && addr) begin
            unique case (phase)
                PH_WAIT_W2: begin
                    vec_base <= wdata[BYTE_W-1:LVL_W];
                    phase    <= phase_after_w2(w1);
                end
                PH_WAIT_W3: begin
                    w3    <= wdata;
                    phase <= phase_after_w3(w1);
                end
                PH_WAIT_W4: begin
                    w4    <= wdata;
                    phase <= PH_READY;
                end
                default: ;
            endcase
        end
    end

    a_r2_capture_first: assert property (@(posedge clk) disable iff (rst)
        phase == PH_WAIT_W1 && wr_en && !addr |=> phase == PH_WAIT_W2 && w1 == $past(wdata));

    a_r3_to_third: assert property (@(posedge clk) disable iff (rst)
        phase == PH_WAIT_W2 && wr_en && addr && !w1.single |=> phase == PH_WAIT_W3);

    a_r3_single_paths: assert property (@(posedge clk) disable iff (rst)
        phase == PH_WAIT_W2 && wr_en && addr && w1.single
        |=> phase == ($past(w1.need_w4) ? PH_WAIT_W4 : PH_READY));

    a_r4_fourth_done: assert property (@(posedge clk) disable iff (rst)
        phase == PH_WAIT_W4 && wr_en && addr |=> phase == PH_READY);

    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        wr_en && !addr && wdata[4] |=> phase == PH_WAIT_W2);

    a_r11_idle_port1: assert property (@(posedge clk) disable iff (rst)
        phase == PH_WAIT_W1 && wr_en && addr |=> phase == PH_WAIT_W1);

    a_r11_mid_port0: assert property (@(posedge clk) disable iff (rst)
        phase != PH_WAIT_W1 && phase != PH_READY && wr_en && !addr && !wdata[4]
        |=> phase == $past(phase));

endmodule

// File: rtl/pic_op_regs.sv
module pic_op_regs
    import pic_cmd_pkg::*;
#(
    parameter logic [1:0] RSEL_RESET = RSEL_REQ
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ready,
    input  logic              restart,
    output logic [BYTE_W-1:0] mask,
    output prio_cmd_t         prio_cmd,
    output logic [1:0]        rd_sel,
    output eoi_t              eoi
);

    prio_cmd_t in_cmd;
    logic      op_wr, prio_wr, sel_wr;

    assign in_cmd  = prio_cmd_t'(wdata);
    assign op_wr   = ready && wr_en && !addr;
    assign prio_wr = op_wr && in_cmd.kind == KIND_PRIO;
    assign sel_wr  = op_wr && in_cmd.kind == KIND_SEL;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (restart) begin
            mask <= '0;
        end else if (ready && wr_en && addr) begin
            mask <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_cmd <= '0;
            eoi      <= '0;
        end else begin
            eoi <= prio_wr ? decode_eoi(in_cmd) : '0;
            if (prio_wr) prio_cmd <= in_cmd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_sel <= RSEL_RESET;
        else if (sel_wr) rd_sel <= wdata[1:0];
    end

    a_r5_mask_load: assert property (@(posedge clk) disable iff (rst)
        ready && wr_en && addr |=> mask == $past(wdata));

    a_r10_mask_clear: assert property (@(posedge clk) disable iff (rst)
        restart |=> mask == '0);

    a_r6_eoi_source: assert property (@(posedge clk) disable iff (rst)
        eoi.valid |-> !$past(rst) && $past(ready && wr_en && !addr)
                      && $past(wdata[5]) && !$past(wdata[7]) && $past(wdata[4:3]) == 2'b00);

    a_r6_eoi_fields: assert property (@(posedge clk) disable iff (rst)
        eoi.valid |-> eoi.level == prio_cmd.level && eoi.specific == prio_cmd.specific);

    a_r7_sel_load: assert property (@(posedge clk) disable iff (rst)
        ready && wr_en && !addr && wdata[4:3] == 2'b01 |=> rd_sel == $past(wdata[1:0]));

endmodule

// File: rtl/pic_read_mux.sv
module pic_read_mux
    import pic_cmd_pkg::*;
(
    input  logic              rd_en,
    input  logic              addr,
    input  logic [1:0]        rd_sel,
    input  logic [BYTE_W-1:0] req_bits,
    input  logic [BYTE_W-1:0] svc_bits,
    input  logic [BYTE_W-1:0] mask,
    output logic [BYTE_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr) begin
                rdata = mask;
            end else begin
                unique case (rd_sel)
                    RSEL_REQ: rdata = req_bits;
                    RSEL_SVC: rdata = svc_bits;
                    default:  rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
    import pic_cmd_pkg::*;
#(
    parameter logic [1:0] RSEL_RESET = 2'b10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic         addr,
    input  logic [7:0]   wdata,
    input  logic [7:0]   req_bits,
    input  logic [7:0]   svc_bits,
    output logic [7:0]   rdata,
    output logic [2:0]   seq_phase,
    output logic         init_done,
    output logic [7:0]   cmd_word,
    output logic [4:0]   vec_base,
    output logic [7:0]   cascade_map,
    output logic [7:0]   mode_word,
    output logic [7:0]   irq_mask,
    output logic [7:0]   last_prio_cmd,
    output logic         eoi_valid,
    output logic         eoi_specific,
    output logic [2:0]   eoi_level
);

    phase_e    phase;
    word1_t    w1;
    logic      restart;
    logic      ready;
    logic [1:0] rd_sel;
    prio_cmd_t prio_cmd;
    eoi_t      eoi;

    pic_init_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .phase    (phase),
        .w1       (w1),
        .vec_base (vec_base),
        .w3       (cascade_map),
        .w4       (mode_word),
        .restart  (restart)
    );

    assign ready = (phase == PH_READY);

    pic_op_regs #(.RSEL_RESET(RSEL_RESET)) u_ops (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .ready    (ready),
        .restart  (restart),
        .mask     (irq_mask),
        .prio_cmd (prio_cmd),
        .rd_sel   (rd_sel),
        .eoi      (eoi)
    );

    pic_read_mux u_rd (
        .rd_en    (rd_en),
        .addr     (addr),
        .rd_sel   (rd_sel),
        .req_bits (req_bits),
        .svc_bits (svc_bits),
        .mask     (irq_mask),
        .rdata    (rdata)
    );

    assign seq_phase     = phase;
    assign init_done     = ready;
    assign cmd_word      = w1;
    assign last_prio_cmd = prio_cmd;
    assign eoi_valid     = eoi.valid;
    assign eoi_specific  = eoi.specific;
    assign eoi_level     = eoi.level;

    a_r9_mask_readback: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(ready && wr_en && addr) && rd_en && addr |-> rdata == $past(wdata));

    a_r8_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == 8'h00);

endmodule

// File: tb/pic_cmd_seq_tb.sv
module pic_cmd_seq_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0, req_bits = '0, svc_bits = '0;
    logic [7:0] rdata, cmd_word, cascade_map, mode_word, irq_mask, last_prio_cmd;
    logic [2:0] seq_phase, eoi_level;
    logic [4:0] vec_base;
    logic       init_done, eoi_valid, eoi_specific;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    pic_cmd_seq u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .req_bits(req_bits), .svc_bits(svc_bits), .rdata(rdata),
        .seq_phase(seq_phase), .init_done(init_done), .cmd_word(cmd_word),
        .vec_base(vec_base), .cascade_map(cascade_map), .mode_word(mode_word),
        .irq_mask(irq_mask), .last_prio_cmd(last_prio_cmd), .eoi_valid(eoi_valid),
        .eoi_specific(eoi_specific), .eoi_level(eoi_level)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic go_ready();
        wr(1'b0, 8'h13);   // single, fourth word needed
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h00);
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 phase", {5'd0, seq_phase}, 8'd0);
        check("R1 mask", irq_mask, 8'h00);
        check("R1 words", cmd_word | cascade_map | mode_word | {3'd0, vec_base}, 8'h00);
        check("R1 prio", last_prio_cmd, 8'h00);
        check("R4 not done", {7'd0, init_done}, 8'd0);
        req_bits = 8'h5A; svc_bits = 8'hA7;
        rd(1'b0, r); check("R1 R8 default select reads requests", r, 8'h5A);
        rd(1'b1, r); check("R9 mask read after reset", r, 8'h00);
        check("R8 idle bus", rdata, 8'h00);

        // R11 port1 write in phase 0 ignored
        wr(1'b1, 8'hFF);
        check("R11 phase0 port1 phase", {5'd0, seq_phase}, 8'd0);
        rd(1'b1, r); check("R11 phase0 port1 mask", r, 8'h00);

        // initialization paths
        for (int c = 0; c < 4; c++) begin
            logic [7:0] w1v;
            logic [4:0] vb;
            logic [2:0] ph;
            w1v = 8'h10 | 8'(c);
            vb  = 5'(c * 7 + 3);
            wr(1'b0, w1v);
            check("R2 phase after word1", {5'd0, seq_phase}, 8'd1);
            check("R2 word1 captured", cmd_word, w1v);
            wr(1'b0, 8'h07);
            check("R11 port0 ignored in phase1", {5'd0, seq_phase}, 8'd1);
            wr(1'b1, {vb, 3'b101});
            check("R3 vector base", {3'd0, vec_base}, {3'd0, vb});
            ph = !w1v[1] ? 3'd2 : (w1v[0] ? 3'd3 : 3'd4);
            check("R3 phase after word2", {5'd0, seq_phase}, {5'd0, ph});
            if (ph == 3'd2) begin
                wr(1'b0, 8'h0F);
                check("R11 port0 ignored in phase2", {5'd0, seq_phase}, 8'd2);
                wr(1'b1, 8'h80 | 8'(c));
                check("R4 cascade map", cascade_map, 8'h80 | 8'(c));
                ph = w1v[0] ? 3'd3 : 3'd4;
                check("R4 phase after word3", {5'd0, seq_phase}, {5'd0, ph});
            end
            if (ph == 3'd3) begin
                wr(1'b0, 8'h00);
                check("R11 port0 ignored in phase3", {5'd0, seq_phase}, 8'd3);
                wr(1'b1, 8'h02 | 8'(c << 2));
                check("R4 mode word", mode_word, 8'h02 | 8'(c << 2));
                check("R4 phase after word4", {5'd0, seq_phase}, 8'd4);
            end
            check("R4 init done", {7'd0, init_done}, 8'd1);
        end

        // R5 R9 mask sweep
        for (int m = 0; m < 256; m++) begin
            wr(1'b1, 8'(m));
            check("R5 mask output", irq_mask, 8'(m));
            rd(1'b1, r); check("R9 mask read", r, 8'(m));
        end

        // R6 R7 R8 R10 command sweep
        req_bits = 8'h3C; svc_bits = 8'hC3;
        for (int b = 0; b < 256; b++) begin
            logic [7:0] cb;
            cb = 8'(b);
            go_ready();
            wr(1'b1, 8'hA5);
            wr(1'b0, cb);
            if (cb[4]) begin
                check("R10 restart phase", {5'd0, seq_phase}, 8'd1);
                check("R10 restart mask", irq_mask, 8'h00);
                check("R10 restart word", cmd_word, cb);
            end else if (!cb[3]) begin
                check("R6 stored command", last_prio_cmd, cb);
                check("R6 strobe", {7'd0, eoi_valid}, {7'd0, cb[5] & ~cb[7]});
                if (cb[5] & ~cb[7]) begin
                    check("R6 specific", {7'd0, eoi_specific}, {7'd0, cb[6]});
                    check("R6 level", {5'd0, eoi_level}, {5'd0, cb[2:0]});
                end
                check("R6 mask kept", irq_mask, 8'hA5);
                check("R6 still ready", {5'd0, seq_phase}, 8'd4);
                @(negedge clk);
                check("R6 strobe one cycle", {7'd0, eoi_valid}, 8'd0);
            end else begin
                rd(1'b0, r);
                check("R7 R8 port0 read", r,
                      cb[1:0] == 2'b10 ? 8'h3C : (cb[1:0] == 2'b11 ? 8'hC3 : 8'h00));
                check("R7 mask kept", irq_mask, 8'hA5);
                wr(1'b0, 8'h0A);   // back to request read-out
            end
        end

        // R10 restart from phase 2
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h00);
        check("R10 reached phase2", {5'd0, seq_phase}, 8'd2);
        wr(1'b0, 8'h1B);
        check("R10 restart mid-sequence", {5'd0, seq_phase}, 8'd1);
        check("R10 restart word", cmd_word, 8'h1B);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule